// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves as a byte-addressable serial EEPROM. Its storage is held in an internal register array. The array size is set by the `MEM_BYTES` parameter, which must be a power of two, and every byte starts at the erased value 0xFF. The block watches the SCL and SDA lines through synchronizers running on the system clock. It detects START, repeated START and STOP conditions. It pulls SDA low through an open-drain enable and never drives the line high.

A controller selects the block with a 7-bit device address and a direction bit. For a write, the controller first sends the memory word address: one byte for arrays up to 2047 bytes, two bytes for arrays of 2048 bytes or more. Any data bytes that follow are stored one after another. For a read, the block returns bytes starting at the current word pointer. When the array is between 256 and 2047 bytes, the low device-address bits select the 256-byte page, so the block answers a run of consecutive device addresses. The word pointer advances after every byte and wraps over the whole array. A STOP keeps the pointer, so a later read with no new address continues where the last access ended.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the block is in the stopped state with word pointer 0, it releases SDA (`sda_oe_o` = 0), and every storage byte reads as 0xFF.
- R2: A STOP (SDA rising while SCL is high) returns the block to the stopped state and leaves the word pointer unchanged. A following read with no new word address returns the byte at that pointer.
- R3: The first byte after a START is {device address[6:0], direction}, where direction 1 means read. The block acknowledges it by holding SDA low in the ninth clock only when the address bits above the page bits equal `BASE_ADDR`. On any other address it leaves SDA released and stays silent until the next START, so the controller reads 1s.
- R4: When `MEM_BYTES` >= 2048 the word address is two bytes, the most significant byte first. Smaller sizes take one byte. After the last word-address byte the block moves to writing.
- R5: For 256 <= `MEM_BYTES` < 2048 the block answers `MEM_BYTES`/256 consecutive device addresses. The low log2(`MEM_BYTES`/256) device-address bits set pointer bits 8 and up, for both reads and writes.
- R6: In the writing state, each data byte is acknowledged, stored at the word pointer, and the pointer is then incremented.
- R7: Each byte read returns the storage byte at the word pointer, and the pointer is then incremented modulo `MEM_BYTES`.
- R8: During writes the word pointer also wraps modulo `MEM_BYTES`, so a byte written after the last location lands at location 0.
- R9: The block changes its SDA drive only while SCL is low. After a read byte the block releases SDA in the ninth clock, and a NACK from the controller ends the read with SDA released.
- R10: A repeated START re-evaluates the device address and direction. A write of the word address followed by a repeated START and a read returns data from that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions check on every cycle that SDA drive begins only after SCL has gone low and that a STOP forces the stopped state without moving the pointer. They also check that the writing state is entered only from addressing and that every byte fetched for a read advances the pointer by one. The bench scenarios are the only place where the data itself is shown: the erased contents, stored and returned byte values, page selection from the device address, wrap at the array end, two-byte addressing on a second instance, and silence on a foreign address. The bench records every acknowledge bit and read byte it observes and compares them, in order, against the values expected from the requirements.

// File: rtl/eeprom_pkg.sv
// Package eeprom_pkg
// Shared state encodings for the I2C EEPROM target.
// Assumes: imported by every module of the block.
package eeprom_pkg;

    // Transfer-level control state, as seen by the memory side
    typedef enum logic [1:0] {
        CTL_STOPPED    = 2'd0,
        CTL_ADDRESSING = 2'd1,
        CTL_READING    = 2'd2,
        CTL_WRITING    = 2'd3
    } ctl_state_e;

    // Bit-level phase of the bus engine
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_DEVADDR = 3'd1,
        PH_RXBYTE  = 3'd2,
        PH_ACKSLOT = 3'd3,
        PH_TXBYTE  = 3'd4,
        PH_HOSTACK = 3'd5
    } phase_e;

endpackage

// File: rtl/eeprom_line_sync.sv
// Module eeprom_line_sync
// Brings SCL and SDA into the clock domain through a flop chain, then
// flags SCL edges and START/STOP conditions (SDA edges with SCL high).
// Assumes: the bus is slow compared with clk, and lines idle high.
module eeprom_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chain stages, generated per parameter
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw line levels
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_i;
                        sda_chain[0] <= sda_i;
                    end
                end
            end else begin : g_next
                // Pass the levels down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_chain[g] <= 1'b1;
                        sda_chain[g] <= 1'b1;
                    end else begin
                        scl_chain[g] <= scl_chain[g-1];
                        sda_chain[g] <= sda_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    // Hold the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[STAGES-1];
            sda_prev <= sda_chain[STAGES-1];
        end
    end

    // Edge and condition decode
    always_comb begin
        scl_o      = scl_chain[STAGES-1];
        sda_o      = sda_chain[STAGES-1];
        scl_rise_o = scl_o & ~scl_prev;
        scl_fall_o = ~scl_o & scl_prev;
        start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
        stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
    end

endmodule

// File: rtl/eeprom_dev_match.sv
// Module eeprom_dev_match
// Compares a received 7-bit device address against the base address,
// ignoring the low PAGE_BITS, and returns those bits as a page number.
// Assumes: PAGE_BITS <= 3.
module eeprom_dev_match #(
    parameter logic [6:0] BASE_ADDR = 7'h50,
    parameter int         PAGE_BITS = 2
) (
    input  logic [6:0] dev_addr_i,
    output logic       hit_o,
    output logic [2:0] page_o
);
    localparam logic [6:0] CMP_MASK  = 7'(7'h7F << PAGE_BITS);
    localparam logic [2:0] PAGE_MASK = 3'((1 << PAGE_BITS) - 1);

    // Masked compare and page extraction
    always_comb begin
        hit_o  = ((dev_addr_i ^ BASE_ADDR) & CMP_MASK) == 7'h00;
        page_o = dev_addr_i[2:0] & PAGE_MASK;
    end

endmodule

// File: rtl/eeprom_store.sv
// Module eeprom_store
// Byte array with one synchronous write port and a combinational read
// port. Reset fills every byte with the erased value 0xFF.
// Assumes: DEPTH == 2**AW.
module eeprom_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o
);
    logic [7:0] cells [DEPTH];

    // Erase on reset, otherwise store one byte when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (wr_en_i) begin
            cells[wr_addr_i] <= wr_data_i;
        end
    end

    // Read the addressed byte
    always_comb begin
        rd_data_o = cells[rd_addr_i];
    end

endmodule

// File: rtl/i2c_eeprom_target.sv
// Module i2c_eeprom_target
// I2C target modelling a serial EEPROM of MEM_BYTES bytes. It receives
// the device address and word address, stores written bytes, returns
// read bytes, and acknowledges through an open-drain SDA enable.
// Assumes: MEM_BYTES is a power of two between 16 and 65536, the bus is
// at least ~8x slower than clk, and one controller owns the bus.
module i2c_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int         MEM_BYTES   = 1024,
    parameter logic [6:0] BASE_ADDR   = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int AW        = $clog2(MEM_BYTES);
    localparam bit TWO_BYTE  = (MEM_BYTES >= 2048);
    localparam int PAGE_BITS = (MEM_BYTES >= 256 && MEM_BYTES < 2048)
                               ? $clog2(MEM_BYTES / 256) : 0;
    localparam bit PAGED     = (PAGE_BITS > 0);

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

    ctl_state_e     ctl_q;
    phase_e         phase_q;
    phase_e         after_ack_q;
    logic [AW-1:0]  ptr_q;
    logic [7:0]     shreg_q;
    logic [7:0]     txsh_q;
    logic [3:0]     bitcnt_q;
    logic           oe_q;
    logic           hostack_q;
    logic           abyte_q;
    logic [2:0]     page_q;

    logic           dev_hit;
    logic [2:0]     dev_page;
    logic [7:0]     rd_byte;
    logic           wr_en;
    logic           byte_done;
    logic           load_tx;
    logic [15:0]    ptr_ext;
    logic [15:0]    word_ptr;
    logic [15:0]    paged_ptr;
    logic [AW-1:0]  ptr_inc;

    eeprom_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_p),
        .stop_o    (stop_p)
    );

    eeprom_dev_match #(
        .BASE_ADDR(BASE_ADDR),
        .PAGE_BITS(PAGE_BITS)
    ) u_match (
        .dev_addr_i(shreg_q[7:1]),
        .hit_o     (dev_hit),
        .page_o    (dev_page)
    );

    eeprom_store #(
        .DEPTH(MEM_BYTES),
        .AW   (AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(ptr_q),
        .wr_data_i(shreg_q),
        .rd_addr_i(ptr_q),
        .rd_data_o(rd_byte)
    );

    // Pointer candidates and strobes for the current cycle
    always_comb begin
        ptr_ext   = 16'(ptr_q);
        ptr_inc   = ptr_q + AW'(1);
        byte_done = scl_fall && (bitcnt_q == 4'd8);
        if (TWO_BYTE) begin
            word_ptr = abyte_q ? {ptr_ext[15:8], shreg_q} : {shreg_q, 8'h00};
        end else begin
            word_ptr = {5'b00000, page_q, shreg_q};
        end
        paged_ptr = PAGED ? {5'b00000, dev_page, ptr_ext[7:0]} : ptr_ext;
        wr_en     = !start_p && !stop_p && (phase_q == PH_RXBYTE)
                    && byte_done && (ctl_q == CTL_WRITING);
        load_tx   = !start_p && !stop_p && scl_fall
                    && (((phase_q == PH_ACKSLOT) && (after_ack_q == PH_TXBYTE))
                        || ((phase_q == PH_HOSTACK) && !hostack_q));
    end

    // Bus engine: bit shifting, byte decisions, pointer and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= CTL_STOPPED;
            phase_q     <= PH_IDLE;
            after_ack_q <= PH_IDLE;
            ptr_q       <= '0;
            shreg_q     <= 8'h00;
            txsh_q      <= 8'h00;
            bitcnt_q    <= 4'd0;
            oe_q        <= 1'b0;
            hostack_q   <= 1'b1;
            abyte_q     <= 1'b0;
            page_q      <= 3'd0;
        end else if (stop_p) begin
            phase_q <= PH_IDLE;
            ctl_q   <= CTL_STOPPED;
            oe_q    <= 1'b0;
        end else if (start_p) begin
            phase_q  <= PH_DEVADDR;
            bitcnt_q <= 4'd0;
            oe_q     <= 1'b0;
        end else if (load_tx) begin
            txsh_q   <= rd_byte;
            oe_q     <= ~rd_byte[7];
            ptr_q    <= ptr_inc;
            bitcnt_q <= 4'd0;
            phase_q  <= PH_TXBYTE;
        end else begin
            case (phase_q)
                PH_DEVADDR: begin
                    if (scl_rise && bitcnt_q != 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (byte_done) begin
                        if (dev_hit) begin
                            oe_q    <= 1'b1;
                            phase_q <= PH_ACKSLOT;
                            page_q  <= dev_page;
                            ptr_q   <= paged_ptr[AW-1:0];
                            if (shreg_q[0]) begin
                                ctl_q       <= CTL_READING;
                                after_ack_q <= PH_TXBYTE;
                            end else begin
                                ctl_q       <= CTL_ADDRESSING;
                                abyte_q     <= 1'b0;
                                after_ack_q <= PH_RXBYTE;
                            end
                        end else begin
                            phase_q <= PH_IDLE;
                        end
                    end
                end
                PH_RXBYTE: begin
                    if (scl_rise && bitcnt_q != 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (byte_done) begin
                        phase_q <= PH_ACKSLOT;
                        if (ctl_q == CTL_ADDRESSING) begin
                            oe_q        <= 1'b1;
                            after_ack_q <= PH_RXBYTE;
                            ptr_q       <= word_ptr[AW-1:0];
                            if (TWO_BYTE && !abyte_q) begin
                                abyte_q <= 1'b1;
                            end else begin
                                abyte_q <= 1'b0;
                                ctl_q   <= CTL_WRITING;
                            end
                        end else if (ctl_q == CTL_WRITING) begin
                            oe_q        <= 1'b1;
                            after_ack_q <= PH_RXBYTE;
                            ptr_q       <= ptr_inc;
                        end else begin
                            oe_q        <= 1'b0;
                            after_ack_q <= PH_IDLE;
                        end
                    end
                end
                PH_ACKSLOT: begin
                    if (scl_fall) begin
                        oe_q     <= 1'b0;
                        bitcnt_q <= 4'd0;
                        phase_q  <= (after_ack_q == PH_RXBYTE) ? PH_RXBYTE : PH_IDLE;
                    end
                end
                PH_TXBYTE: begin
                    if (scl_fall) begin
                        if (bitcnt_q == 4'd7) begin
                            oe_q    <= 1'b0;
                            phase_q <= PH_HOSTACK;
                        end else begin
                            txsh_q   <= {txsh_q[6:0], 1'b0};
                            oe_q     <= ~txsh_q[6];
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end
                    end
                end
                PH_HOSTACK: begin
                    if (scl_rise) begin
                        hostack_q <= sda_s;
                    end else if (scl_fall) begin
                        oe_q    <= 1'b0;
                        phase_q <= PH_IDLE;
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe_o = oe_q;

    // Drive begins only in a cycle that follows SCL low
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !$past(scl_s)); // R9

    // STOP forces the stopped state
    AST_STOP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (ctl_q == CTL_STOPPED)); // R2

    // STOP keeps the word pointer
    AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (ptr_q == $past(ptr_q))); // R2

    // Writing is entered only from addressing
    AST_WRITE_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q == CTL_WRITING) && ($past(ctl_q) != CTL_WRITING))
        |-> ($past(ctl_q) == CTL_ADDRESSING)); // R4

    // Every fetched read byte advances the pointer by one, wrapping
    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        load_tx |=> (ptr_q == AW'($past(ptr_q) + AW'(1)))); // R7

    // No drive while the engine is idle
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) && $past(phase_q == PH_IDLE) |-> !oe_q); // R3

endmodule

// File: tb/i2c_eeprom_target_tb.sv
// Bench for i2c_eeprom_target: a bit-banged controller drives a shared
// open-drain bus with two instances (paged 1024-byte and two-byte
// 2048-byte). Driver tasks queue expected items, a monitor compares.
module i2c_eeprom_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;

    typedef struct {
        int    val;
        string tag;
    } exp_item_t;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic m_low = 1'b0;
    logic oe_a, oe_b;
    logic sda_line;

    exp_item_t exp_q[$];
    int        obs_q[$];
    event      obs_ev;
    int        errors = 0;
    int        checks = 0;
    bit        done   = 1'b0;

    assign sda_line = !(m_low || oe_a || oe_b);

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_eeprom_target #(
        .MEM_BYTES(1024),
        .BASE_ADDR(7'h50)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe_o(oe_a)
    );

    i2c_eeprom_target #(
        .MEM_BYTES(2048),
        .BASE_ADDR(7'h68)
    ) dut_w (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe_o(oe_b)
    );

    task automatic qwait();
        repeat (QTR) @(posedge clk);
        #2;
    endtask

    task automatic expect_item(int v, string tag);
        exp_item_t it;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic observe(int v);
        obs_q.push_back(v);
        -> obs_ev;
    endtask

    task automatic direct_check(int act, int expv, string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic wbit(bit b);
        qwait();
        m_low = !b;
        qwait();
        scl = 1'b1;
        qwait();
        qwait();
        scl = 1'b0;
    endtask

    task automatic rbit(output bit b);
        qwait();
        m_low = 1'b0;
        qwait();
        scl = 1'b1;
        qwait();
        b = sda_line;
        qwait();
        scl = 1'b0;
    endtask

    task automatic start_c();
        m_low = 1'b1;
        qwait();
        scl = 1'b0;
    endtask

    task automatic restart_c();
        qwait();
        m_low = 1'b0;
        qwait();
        scl = 1'b1;
        qwait();
        m_low = 1'b1;
        qwait();
        scl = 1'b0;
    endtask

    task automatic stop_c();
        qwait();
        m_low = 1'b1;
        qwait();
        scl = 1'b1;
        qwait();
        m_low = 1'b0;
        qwait();
    endtask

    // Send a byte; the ninth-clock level (0 = ACK) is observed
    task automatic wbyte(logic [7:0] b);
        bit a;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(a);
        observe(int'(a));
    endtask

    // Receive a byte and answer with ACK (0) or NACK (1)
    task automatic rbyte(bit nack);
        logic [7:0] d;
        bit         b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(nack);
        observe(int'(d));
    endtask

    // Write bytes with acks expected; caller supplies tags
    task automatic wr_ack(logic [7:0] b, string tag);
        expect_item(0, tag);
        wbyte(b);
    endtask

    task automatic rd_exp(logic [7:0] v, bit nack, string tag);
        expect_item(int'(v), tag);
        rbyte(nack);
    endtask

    // Monitor: compare observed items against expected in order
    initial begin
        forever begin
            @(obs_ev);
            while (obs_q.size() > 0) begin
                int        o;
                exp_item_t e;
                o = obs_q.pop_front();
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected item: actual=0x%0h expected=none", o);
                end else begin
                    e = exp_q.pop_front();
                    if (o != e.val) begin
                        errors++;
                        $display("FAIL %s: actual=0x%0h expected=0x%0h", e.tag, o, e.val);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Scenario driver
    initial begin
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #2;

        // R1: line released after reset, erased read at pointer 0
        direct_check(int'(sda_line), 1, "R1 sda released after reset");
        start_c();
        wr_ack(8'hA1, "R1 ack read address");
        rd_exp(8'hFF, 1'b1, "R1 erased byte");
        stop_c();

        // R6: write three bytes at 0x010
        start_c();
        wr_ack(8'hA0, "R6 ack device");
        wr_ack(8'h10, "R6 ack word");
        wr_ack(8'hA1, "R6 ack data0");
        wr_ack(8'hA2, "R6 ack data1");
        wr_ack(8'hA3, "R6 ack data2");
        stop_c();

        // R10: random read via repeated START
        start_c();
        wr_ack(8'hA0, "R10 ack device");
        wr_ack(8'h10, "R10 ack word");
        restart_c();
        wr_ack(8'hA1, "R10 ack read");
        rd_exp(8'hA1, 1'b0, "R10 first byte");
        rd_exp(8'hA2, 1'b1, "R7 increment");
        // R9: master NACK ends read, SDA released
        direct_check(int'(sda_line), 1, "R9 released after NACK");
        stop_c();

        // R2: current-address read continues after STOP
        start_c();
        wr_ack(8'hA1, "R2 ack read");
        rd_exp(8'hA3, 1'b1, "R2 pointer kept");
        stop_c();
        direct_check(int'(sda_line), 1, "R9 idle line after stop");

        // R5: page bits from device address
        start_c();
        wr_ack(8'hA4, "R5 ack page2 device");
        wr_ack(8'h05, "R5 ack word");
        wr_ack(8'h5C, "R5 ack data");
        stop_c();
        start_c();
        wr_ack(8'hA0, "R5 ack page0");
        wr_ack(8'h05, "R5 ack word");
        restart_c();
        wr_ack(8'hA1, "R5 ack read page0");
        rd_exp(8'hFF, 1'b1, "R5 other page untouched");
        stop_c();
        start_c();
        wr_ack(8'hA4, "R5 ack page2");
        wr_ack(8'h05, "R5 ack word");
        restart_c();
        wr_ack(8'hA5, "R5 ack read page2");
        rd_exp(8'h5C, 1'b1, "R5 page2 data");
        stop_c();

        // R3: foreign address refused and silent
        start_c();
        expect_item(1, "R3 nack write foreign");
        wbyte(8'hAE);
        stop_c();
        start_c();
        expect_item(1, "R3 nack read foreign");
        wbyte(8'hAF);
        rd_exp(8'hFF, 1'b1, "R3 silent line");
        stop_c();

        // R8: write wrap from 0x3FF to 0x000
        start_c();
        wr_ack(8'hA6, "R8 ack page3");
        wr_ack(8'hFF, "R8 ack word");
        wr_ack(8'hB0, "R8 ack last");
        wr_ack(8'hB1, "R8 ack wrapped");
        stop_c();
        start_c();
        wr_ack(8'hA0, "R8 ack device");
        wr_ack(8'h00, "R8 ack word");
        restart_c();
        wr_ack(8'hA1, "R8 ack read");
        rd_exp(8'hB1, 1'b1, "R8 wrapped byte at 0");
        stop_c();

        // R7: read wrap from 0x3FF to 0x000
        start_c();
        wr_ack(8'hA6, "R7 ack page3");
        wr_ack(8'hFF, "R7 ack word");
        restart_c();
        wr_ack(8'hA7, "R7 ack read");
        rd_exp(8'hB0, 1'b0, "R7 last byte");
        rd_exp(8'hB1, 1'b1, "R7 wrap to 0");
        stop_c();

        // R4: two-byte word address on the 2048-byte instance
        start_c();
        wr_ack(8'hD0, "R4 ack device");
        wr_ack(8'h07, "R4 ack high");
        wr_ack(8'hFE, "R4 ack low");
        wr_ack(8'hC0, "R4 ack d0");
        wr_ack(8'hC1, "R4 ack d1");
        wr_ack(8'hC2, "R4 ack d2");
        stop_c();
        start_c();
        wr_ack(8'hD0, "R4 ack device");
        wr_ack(8'h07, "R4 ack high");
        wr_ack(8'hFE, "R4 ack low");
        restart_c();
        wr_ack(8'hD1, "R4 ack read");
        rd_exp(8'hC0, 1'b0, "R4 byte 0x7FE");
        rd_exp(8'hC1, 1'b0, "R4 byte 0x7FF");
        rd_exp(8'hC2, 1'b1, "R8 two-byte wrap");
        stop_c();
        start_c();
        wr_ack(8'hD0, "R4 ack device");
        wr_ack(8'h00, "R4 ack high");
        wr_ack(8'h00, "R4 ack low");
        restart_c();
        wr_ack(8'hD1, "R4 ack read");
        rd_exp(8'hC2, 1'b1, "R4 msb first at 0");
        stop_c();

        repeat (20) @(posedge clk);
        #2;
        direct_check(exp_q.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule